// File: doc/BRIEF.md
# Direct-Mapped L1 Data Cache

This block is a 32 KiB direct-mapped data cache that sits between a CPU load/store port and a memory-side request/response port. Each 32-byte line has a tag, a valid bit and a dirty bit. Tag storage is read combinationally. Line storage is read through a one-cycle registered port. Stores of byte, halfword and word size that hit are merged into the line with per-byte enables. Loads that hit return their word one cycle after the lookup.

On a miss the cache fetches the whole line in a single 256-bit memory transaction. If the line being replaced is valid and dirty, that line is first sent back to memory in one 256-bit write. A level input chooses the write policy at run time. In write-back mode, store hits stay inside the cache and mark the line dirty. In write-through mode, store hits also go out to memory as a single word write and leave the dirty bit unchanged.

Addresses whose upper 16 bits are all ones form the I/O window. They never allocate a line. Each such access goes out as one uncached word transfer. The CPU holds its request until `cpu_stall` is low, and that cycle completes the access.

Top module: `dc_l1d`

## Requirements
- R1: After reset every line is invalid. With no CPU request, `cpu_stall`, `mem_rd` and `mem_wr` are all low, and the first load to any cacheable address misses.
- R2: A load that hits stalls for exactly one cycle. In the following cycle `cpu_stall` is low and `cpu_rdata` holds the addressed word, and no memory transfer is made.
- R3: A load miss whose indexed line is invalid or clean issues exactly one line read (`mem_line`=1). Its address is the request address with bits [4:0] cleared. The load then returns the requested word from the refilled line.
- R4: A miss whose indexed line is valid, dirty and holds a different tag first issues one line write. That write goes to {stored tag, index, 5'b0} and carries the old line contents. The line read for the new address follows it.
- R5: A store changes only the bytes it addresses. `cpu_size` 0 is a byte at offset [1:0], 1 is a halfword at offset [1] (bytes 1:0 or 3:2), and 2 is a full word. Later loads return the merged data.
- R6: In write-back mode (`wt_mode`=0), a store hit completes with no stall and no memory transfer, and it marks the line dirty.
- R7: In write-through mode (`wt_mode`=1), a store hit issues one word write (`mem_line`=0) to the store address. `mem_wstrb` holds the byte enables and `mem_wdata[31:0]` holds the store data replicated across the lanes. The line does not become dirty, so evicting it causes no line write.
- R8: An address with bits [31:16] equal to 16'hFFFF bypasses the cache. Each such load or store is one word transfer with `mem_line`=0, and a load returns `mem_rdata[31:0]`. Nothing is allocated, so a repeated load goes to memory again.
- R9: On the memory port, `mem_rd` and `mem_wr` are never high together. A request keeps its address stable until `mem_done` arrives, and it is dropped on the edge after `mem_done`.
- R10: `cpu_stall` is high while a requested access is still in progress. It goes low in the cycle the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back |
| cpu_rd | input | 1 | Load request, held until stall is low |
| cpu_wr | input | 1 | Store request, held until stall is low |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_rdata | output | 32 | Load data, valid when stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_line | output | 1 | 1 = whole-line transfer, 0 = single word |
| mem_addr | output | 32 | Memory request address |
| mem_wstrb | output | 4 | Byte enables of a word write |
| mem_wdata | output | 256 | Line data, or a word in bits [31:0] |
| mem_rdata | input | 256 | Line data, or a word in bits [31:0] |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
Directed patterns first walk a single line through each transition in turn: cold miss, hit, write-back store, dirty eviction, write-through store, clean eviction and I/O access. The memory-traffic log then shows whether a line read, a line write or a word transfer was issued and to which address. A stall count of exactly one on a hit load, and zero on a write-back store hit, separates the two hit paths from the miss paths. A constrained-random phase then mixes loads and stores of all three sizes over four tags that share eight indexes, toggles the write policy, and varies the memory latency. Every load is compared against a byte-exact shadow image, which catches lost merges, stale refills and dropped write-backs.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HITRD,
      ST_EVICT,
      ST_REFILL,
      ST_BYPASS,
      ST_THRU
   } dc_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/dc_meta.sv
module dc_meta #(
   parameter int LINES = 1024,
   parameter int TAG_W = 17,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_we,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set,
   output logic             valid_o,
   output logic             dirty_o,
   output logic [TAG_W-1:0] tag_o
);
   logic [LINES-1:0] vld_q;
   logic [LINES-1:0] drt_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         drt_q <= '0;
      end else if (fill_we) begin
         vld_q[idx] <= 1'b1;
         drt_q[idx] <= 1'b0;
      end else if (dirty_set) begin
         drt_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) tag_q[idx] <= fill_tag;
   end

   assign valid_o = vld_q[idx];
   assign dirty_o = drt_q[idx];
   assign tag_o   = tag_q[idx];
endmodule

// File: rtl/dc_data.sv
module dc_data #(
   parameter int LINES      = 1024,
   parameter int LINE_BYTES = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WORDS  = LINE_BYTES / 4,
   localparam int WOFF_W = $clog2(WORDS),
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WOFF_W-1:0] word_off,
   input  logic              fill_we,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              word_we,
   input  logic [3:0]        byte_en,
   input  logic [31:0]       wword,
   output logic [LINE_W-1:0] line_q
);
   logic [LINE_W-1:0]     ram [LINES];
   logic [LINE_BYTES-1:0] lane_we;

   for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
      assign lane_we[g] = word_we && byte_en[g % 4] && (word_off == WOFF_W'(g / 4));
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         ram[idx] <= fill_line;
      end else begin
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (lane_we[b]) ram[idx][8*b +: 8] <= wword[8*(b % 4) +: 8];
         end
      end
      line_q <= ram[idx];
   end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
   import dc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd,
   input  logic wr,
   input  logic is_io,
   input  logic hit,
   input  logic vic_dirty,
   input  logic wt_mode,
   input  logic mem_done,
   output logic stall,
   output logic fill_we,
   output logic dirty_set,
   output logic word_we,
   output logic mem_rd,
   output logic mem_wr,
   output logic mem_line,
   output logic sel_victim,
   output logic sel_mem
);
   dc_state_e st_q, st_d;
   logic      req;

   assign req = rd | wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d       = st_q;
      stall      = 1'b0;
      fill_we    = 1'b0;
      dirty_set  = 1'b0;
      word_we    = 1'b0;
      mem_rd     = 1'b0;
      mem_wr     = 1'b0;
      mem_line   = 1'b0;
      sel_victim = 1'b0;
      sel_mem    = 1'b0;
      unique case (st_q)
         ST_IDLE: if (req) begin
            stall = 1'b1;
            if (is_io) begin
               st_d = ST_BYPASS;
            end else if (hit && rd) begin
               st_d = ST_HITRD;
            end else if (hit) begin
               word_we = 1'b1;
               if (wt_mode) begin
                  st_d = ST_THRU;
               end else begin
                  dirty_set = 1'b1;
                  stall     = 1'b0;
               end
            end else if (vic_dirty) begin
               st_d = ST_EVICT;
            end else begin
               st_d = ST_REFILL;
            end
         end
         ST_HITRD: st_d = ST_IDLE;
         ST_EVICT: begin
            stall      = 1'b1;
            mem_wr     = 1'b1;
            mem_line   = 1'b1;
            sel_victim = 1'b1;
            if (mem_done) st_d = ST_REFILL;
         end
         ST_REFILL: begin
            stall    = 1'b1;
            mem_rd   = 1'b1;
            mem_line = 1'b1;
            if (mem_done) begin
               fill_we = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_BYPASS: begin
            stall   = !mem_done;
            mem_rd  = rd;
            mem_wr  = wr;
            sel_mem = 1'b1;
            if (mem_done) st_d = ST_IDLE;
         end
         ST_THRU: begin
            stall  = !mem_done;
            mem_wr = 1'b1;
            if (mem_done) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/dc_l1d.sv
module dc_l1d
   import dc_pkg::*;
#(
   parameter int               ADDR_W      = 32,
   parameter int               LINE_BYTES  = 32,
   parameter int               LINES       = 1024,
   parameter int               IO_PREFIX_W = 16,
   parameter logic [IO_PREFIX_W-1:0] IO_PREFIX = '1,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int WOFF_W = OFF_W - 2,
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wt_mode,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_line,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_wstrb,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_done
);
   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 8) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if (IO_PREFIX_W > TAG_W) begin : g_bad_io
      $error("I/O prefix must lie within the tag field");
   end

   logic [TAG_W-1:0]  a_tag, m_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [WOFF_W-1:0] a_woff;
   logic [1:0]        a_boff;
   logic              is_io, m_valid, m_dirty, hit, vic_dirty;
   logic              fill_we, dirty_set, word_we, sel_victim, sel_mem;
   logic [3:0]        be;
   logic [31:0]       wrep;
   logic [LINE_W-1:0] line_q;

   assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx  = cpu_addr[OFF_W +: IDX_W];
   assign a_woff = cpu_addr[2 +: WOFF_W];
   assign a_boff = cpu_addr[1:0];
   assign is_io  = cpu_addr[ADDR_W-1 -: IO_PREFIX_W] == IO_PREFIX;

   always_comb begin
      unique case (cpu_size)
         SZ_BYTE: begin
            be   = 4'b0001 << a_boff;
            wrep = {4{cpu_wdata[7:0]}};
         end
         SZ_HALF: begin
            be   = a_boff[1] ? 4'b1100 : 4'b0011;
            wrep = {2{cpu_wdata[15:0]}};
         end
         default: begin
            be   = 4'b1111;
            wrep = cpu_wdata;
         end
      endcase
   end

   assign hit       = m_valid && (m_tag == a_tag);
   assign vic_dirty = m_valid && m_dirty && !hit;

   dc_meta #(.LINES(LINES), .TAG_W(TAG_W)) i_meta (
      .clk(clk), .rst_n(rst_n), .idx(a_idx),
      .fill_we(fill_we), .fill_tag(a_tag), .dirty_set(dirty_set),
      .valid_o(m_valid), .dirty_o(m_dirty), .tag_o(m_tag)
   );

   dc_data #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_data (
      .clk(clk), .idx(a_idx), .word_off(a_woff),
      .fill_we(fill_we), .fill_line(mem_rdata),
      .word_we(word_we), .byte_en(be), .wword(wrep),
      .line_q(line_q)
   );

   dc_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .wr(cpu_wr),
      .is_io(is_io), .hit(hit), .vic_dirty(vic_dirty), .wt_mode(wt_mode),
      .mem_done(mem_done), .stall(cpu_stall), .fill_we(fill_we),
      .dirty_set(dirty_set), .word_we(word_we), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_line(mem_line), .sel_victim(sel_victim),
      .sel_mem(sel_mem)
   );

   always_comb begin
      if (sel_victim)    mem_addr = {m_tag, a_idx, {OFF_W{1'b0}}};
      else if (mem_line) mem_addr = {a_tag, a_idx, {OFF_W{1'b0}}};
      else               mem_addr = cpu_addr;
   end

   assign mem_wstrb = be;
   assign mem_wdata = mem_line ? line_q : {{(LINE_W-32){1'b0}}, wrep};
   assign cpu_rdata = sel_mem ? mem_rdata[31:0] : line_q[32*a_woff +: 32];
endmodule

// File: rtl/dc_checks.sv
module dc_checks #(
   parameter int ADDR_W      = 32,
   parameter int IO_PREFIX_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              cpu_stall,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_line,
   input logic              mem_done,
   input logic [ADDR_W-1:0] mem_addr
);
   AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) && !mem_done |=> (mem_rd || mem_wr) && $stable(mem_addr)); // R9
   AST_RD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && mem_done |=> !mem_rd); // R9
   AST_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && mem_done |=> !mem_wr); // R9
   AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) && mem_line |-> mem_addr[4:0] == 5'd0); // R3
   AST_IO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) && (&mem_addr[ADDR_W-1 -: IO_PREFIX_W]) |-> !mem_line); // R8
   AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd && !cpu_stall |-> $past(cpu_stall)); // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_rd || cpu_wr) |-> !cpu_stall); // R10
endmodule

bind dc_l1d dc_checks #(.ADDR_W(ADDR_W), .IO_PREFIX_W(IO_PREFIX_W)) i_dc_checks (
   .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
   .cpu_stall(cpu_stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .mem_line(mem_line), .mem_done(mem_done), .mem_addr(mem_addr)
);

// File: tb/test_dc_l1d.sv
module test_dc_l1d;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wt_mode = 1'b0;
   logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [31:0]  cpu_addr = '0;
   logic [1:0]   cpu_size = 2'd2;
   logic [31:0]  cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_stall, mem_rd, mem_wr, mem_line;
   logic [31:0]  mem_addr;
   logic [3:0]   mem_wstrb;
   logic [255:0] mem_wdata;
   logic [255:0] mem_rdata;
   logic         mem_done;

   int chk = 0, err = 0, proto_err = 0, lat_max = 0;
   logic [255:0] bmem [32];
   logic [255:0] gold [32];
   int          ev_n;
   logic [1:0]  ev_kind [8];
   logic [31:0] ev_addr [8];
   logic [31:0] ev_data [8];
   logic [3:0]  ev_strb [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   dc_l1d i_dc_l1d (.*);

   function automatic int lidx(logic [31:0] a);
      return int'({a[16:15], a[7:5]});
   endfunction

   function automatic logic [31:0] gword(logic [31:0] a);
      return gold[lidx(a)][32*a[4:2] +: 32];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      chk++;
      if (act !== exp) begin
         err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", chk, err);
      $finish;
   endtask

   // memory responder, acts 2 time units after each rising edge
   initial begin
      int wait_cnt = 0, cur_lat = 0;
      logic pend = 1'b0;
      logic [31:0] pend_addr = '0;
      mem_done = 1'b0;
      mem_rdata = '0;
      forever begin
         @(posedge clk); #2;
         if (mem_done) begin
            mem_done = 1'b0;
         end else if (mem_rd || mem_wr) begin
            if (pend && mem_addr !== pend_addr) proto_err++;
            pend = 1'b1;
            pend_addr = mem_addr;
            if (wait_cnt >= cur_lat) begin
               if (ev_n < 8) begin
                  ev_kind[ev_n] = {mem_wr, mem_line};
                  ev_addr[ev_n] = mem_addr;
                  ev_data[ev_n] = mem_wdata[31:0];
                  ev_strb[ev_n] = mem_wstrb;
                  ev_n++;
               end
               if (mem_wr && mem_line) begin
                  bmem[lidx(mem_addr)] = mem_wdata;
               end else if (mem_wr && mem_addr[31:16] != 16'hFFFF) begin
                  for (int b = 0; b < 4; b++)
                     if (mem_wstrb[b])
                        bmem[lidx(mem_addr)][32*mem_addr[4:2] + 8*b +: 8] = mem_wdata[8*b +: 8];
               end
               if (mem_rd) begin
                  if (mem_line) mem_rdata = bmem[lidx(mem_addr)];
                  else if (mem_addr[31:16] == 16'hFFFF)
                     mem_rdata = {224'd0, 16'hC0DE, mem_addr[15:0]};
                  else mem_rdata = {224'd0, bmem[lidx(mem_addr)][32*mem_addr[4:2] +: 32]};
               end
               mem_done = 1'b1;
               wait_cnt = 0;
               pend = 1'b0;
               cur_lat = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   task automatic access(input bit rd, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rdv, output int stalls);
      cpu_rd = rd; cpu_wr = !rd; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
      stalls = 0;
      forever begin
         @(negedge clk);
         if (!cpu_stall) break;
         stalls++;
         if (stalls > 200) begin
            err++; chk++;
            $display("FAIL R10: actual stuck stall expected completion");
            break;
         end
      end
      rdv = cpu_rdata;
      if (!rd && a[31:16] != 16'hFFFF) begin
         for (int b = 0; b < 4; b++) begin
            logic [3:0]  be;
            logic [31:0] rep;
            be  = (sz == 2'd0) ? (4'b0001 << a[1:0]) :
                  (sz == 2'd1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
            rep = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
            if (be[b]) gold[lidx(a)][32*a[4:2] + 8*b +: 8] = rep[8*b +: 8];
         end
      end
      @(posedge clk); #2;
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      err++; chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] rv;
      int st;
      void'($urandom(32'd4711));
      ev_n = 0;
      for (int i = 0; i < 32; i++)
         for (int w = 0; w < 8; w++) begin
            bmem[i][32*w +: 32] = {8'(i), 8'(w), 16'h3C00 + 16'(i * 8 + w)};
            gold[i][32*w +: 32] = bmem[i][32*w +: 32];
         end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      @(negedge clk);
      check("R1 idle stall", {31'd0, cpu_stall}, 32'd0);
      check("R1 idle mem req", {30'd0, mem_rd, mem_wr}, 32'd0);
      @(posedge clk); #2;

      ev_n = 0; access(1, 32'h0000_0104, 2'd2, 0, rv, st);
      check("R3 cold miss traffic", ev_n, 1);
      check("R3 line read kind", {30'd0, ev_kind[0]}, 32'b01);
      check("R3 line read addr", ev_addr[0], 32'h0000_0100);
      check("R3 refill data", rv, gword(32'h104));

      ev_n = 0; access(1, 32'h0000_0108, 2'd2, 0, rv, st);
      check("R2 hit stalls", st, 1);
      check("R2 hit traffic", ev_n, 0);
      check("R2 hit data", rv, gword(32'h108));

      wt_mode = 1'b0;
      ev_n = 0; access(0, 32'h0000_0105, 2'd0, 32'h0000_005A, rv, st);
      check("R6 wb store stalls", st, 0);
      check("R6 wb store traffic", ev_n, 0);
      ev_n = 0; access(1, 32'h0000_0104, 2'd2, 0, rv, st);
      check("R5 byte merge", rv, gword(32'h104));

      ev_n = 0; access(1, 32'h0000_8104, 2'd2, 0, rv, st);
      check("R4 evict traffic", ev_n, 2);
      check("R4 first is line write", {30'd0, ev_kind[0]}, 32'b11);
      check("R4 victim addr", ev_addr[0], 32'h0000_0100);
      check("R4 victim data", bmem[lidx(32'h100)][63:32], gold[lidx(32'h100)][63:32]);
      check("R4 then line read", ev_addr[1], 32'h0000_8100);
      check("R4 new data", rv, gword(32'h8104));

      wt_mode = 1'b1;
      ev_n = 0; access(1, 32'h0000_0200, 2'd2, 0, rv, st);
      ev_n = 0; access(0, 32'h0000_0202, 2'd1, 32'h0000_1234, rv, st);
      check("R7 wt store traffic", ev_n, 1);
      check("R7 word write kind", {30'd0, ev_kind[0]}, 32'b10);
      check("R7 word write addr", ev_addr[0], 32'h0000_0202);
      check("R7 word strobe", {28'd0, ev_strb[0]}, 32'hC);
      check("R7 word data", {16'd0, ev_data[0][31:16]}, 32'h1234);
      check("R10 wt store stalls", st, 1);
      ev_n = 0; access(1, 32'h0000_8200, 2'd2, 0, rv, st);
      check("R7 clean evict no write", ev_n, 1);
      check("R7 clean evict read", {30'd0, ev_kind[0]}, 32'b01);

      for (int k = 0; k < 2; k++) begin
         ev_n = 0; access(1, 32'hFFFF_0124, 2'd2, 0, rv, st);
         check("R8 io read traffic", ev_n, 1);
         check("R8 io word read", {30'd0, ev_kind[0]}, 32'b00);
         check("R8 io data", rv, 32'hC0DE_0124);
      end
      ev_n = 0; access(0, 32'hFFFF_0130, 2'd2, 32'h1, rv, st);
      check("R8 io write kind", {30'd0, ev_kind[0]}, 32'b10);
      check("R8 io write addr", ev_addr[0], 32'hFFFF_0130);

      lat_max = 2;
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         bit          rd;
         if ($urandom % 8 == 0) wt_mode = ~wt_mode;
         sz = 2'($urandom % 3);
         a  = {15'd0, 2'($urandom), 7'd0, 3'($urandom), 5'($urandom)};
         if (sz == 2'd1) a[0] = 1'b0;
         if (sz == 2'd2) a[1:0] = 2'b00;
         rd = ($urandom % 2) == 0;
         ev_n = 0;
         access(rd, a, sz, $urandom, rv, st);
         if (rd) check("R5 random load", rv, gword(a));
      end
      check("R9 address held while waiting", proto_err, 0);
      summary();
   end
endmodule